// File: doc/BRIEF.md
# Indexed Event Performance Counter Unit

This block holds a bank of event counters for a processor core. Each counter watches one line of an event vector, chosen by a condition code in its configuration word. It can be limited to cycles where the core runs in kernel mode or cycles where it runs in user mode. A single run bit starts and stops the whole bank. Software reaches every per-counter register through one counter-select register. It reads a running counter through a snapshot pair, so a wide value cannot tear between its two halves. It writes a counter through separate low and high words.

Each counter also has a 64-bit threshold. When an increment lands the count on that threshold, and the counter's interrupt enable is set, the counter's sticky active bit sets. The interrupt output is high while any active bit meets its enable. Writing ones to the active register clears those active bits and disarms the matching enables as well, so software must re-arm a counter after it services it.

The register bus is a plain one-cycle interface. A write takes effect at the clock edge where `bus_wr` is high, and a read returns data combinationally from `bus_addr`. The bus has no back-pressure, so every access completes at once. The event vector and the privilege input are sampled at every clock edge.

Top module: `perf_counter_unit`

## Requirements
- R1: Word addresses are: 0 control, 1 counter select, 2 config, 3 count low, 4 count high, 5 snapshot low, 6 snapshot high, 7 threshold low, 8 threshold high, 9 interrupt enable, 10 interrupt active. The config, count and threshold addresses act only on the counter named by the select register, and the other counters keep their values.
- R2: Config bits 14:0 hold a condition code. Code k, with k from 1 to NUM_EVT, makes the counter add one at each clock edge where `evt_in[k-1]` is high. Code 0, and any code above NUM_EVT, never counts.
- R3: Control bit 0 is the global run bit. While it is 0, no counter increments.
- R4: Config bit 16 restricts counting to edges with `priv_kernel` high. Config bit 17 restricts counting to edges with `priv_kernel` low. With neither bit set, the counter counts in both modes.
- R5: A write to count low replaces bits 31:0, and a write to count high replaces the bits above 31. Each takes effect at its write edge and overrides an increment at that same edge.
- R6: A counter is 32+16*SIZE_SEL bits wide and wraps to zero. Count-high bits beyond the width read as zero.
- R7: Writing control with bit 1 set copies the selected counter's value from before that edge into the snapshot pair, which reads back at addresses 5 and 6. Control reads back the run bit in bit 0 and zero elsewhere.
- R8: When an increment makes a counter equal its 64-bit threshold while its interrupt-enable bit is set, its active bit sets. `irq` is high while any counter has both its active bit and its enable bit set.
- R9: Writing the active register clears each active bit written as 1 and also clears the matching enable bit. Writing all ones clears every pending flag.
- R10: A counter whose enable bit is clear never sets its active bit when it reaches its threshold.
- R11: After reset all counters, configs, thresholds, enables, active bits, the run bit and the select register are zero, and `irq` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | ADDR_W | Register word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr |
| evt_in | input | NUM_EVT | Countable condition lines |
| priv_kernel | input | 1 | High while the core runs in kernel mode |
| irq | output | 1 | Threshold interrupt request |

## Verification
A count register write and an increment of the same counter can land on the same clock edge. The bench provokes this by holding an enabled event line high while it writes count low and then count high. It expects the written word to appear exactly, and the other half to hold the value reached just before the write edge. A snapshot request can also coincide with an increment. The bench expects the snapshot to equal the live count minus one, and checks both against a count it works out by counting edges.

// File: rtl/pcu_pkg.sv
package pcu_pkg;
  localparam int A_CTRL  = 0;
  localparam int A_SEL   = 1;
  localparam int A_CFG   = 2;
  localparam int A_CLO   = 3;
  localparam int A_CHI   = 4;
  localparam int A_SLO   = 5;
  localparam int A_SHI   = 6;
  localparam int A_TLO   = 7;
  localparam int A_THI   = 8;
  localparam int A_IEN   = 9;
  localparam int A_IACT  = 10;
  localparam int CODE_W  = 15;
  localparam int KERN_BIT = 16;
  localparam int USER_BIT = 17;
  localparam logic [31:0] CFG_MASK = 32'h0003_7FFF;
endpackage

// File: rtl/pcu_slice.sv
module pcu_slice #(
  parameter int NUM_EVT = 8,
  parameter int CW      = 48
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               run,
  input  logic               priv_kernel,
  input  logic [NUM_EVT-1:0] evt_in,
  input  logic               wr_cfg,
  input  logic               wr_clo,
  input  logic               wr_chi,
  input  logic               wr_tlo,
  input  logic               wr_thi,
  input  logic [31:0]        wdata,
  output logic [31:0]        cfg_o,
  output logic [63:0]        cnt_o,
  output logic [63:0]        thr_o,
  output logic               hit_o
);
  import pcu_pkg::*;

  logic [31:0]   cfg_q;
  logic [CW-1:0] cnt_q;
  logic [63:0]   thr_q;
  logic [CODE_W-1:0] code;
  logic          evt_sel, mode_ok, inc, any_wr;
  logic [CW-1:0] cnt_inc;
  logic [63:0]   wide;
  logic          unused_hi;

  assign code = cfg_q[CODE_W-1:0];

  always_comb begin
    evt_sel = 1'b0;
    for (int k = 0; k < NUM_EVT; k++)
      if (code == CODE_W'(k + 1)) evt_sel = evt_in[k];
  end

  assign mode_ok = !(cfg_q[KERN_BIT] && !priv_kernel) && !(cfg_q[USER_BIT] && priv_kernel);
  assign inc     = run && evt_sel && mode_ok;
  assign any_wr  = wr_clo || wr_chi;
  assign cnt_inc = cnt_q + CW'(1);

  always_comb begin
    wide = 64'(cnt_q);
    if (wr_clo) wide[31:0]  = wdata;
    if (wr_chi) wide[63:32] = wdata;
  end
  assign unused_hi = ^wide[63:CW];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q <= '0;
      cnt_q <= '0;
      thr_q <= '0;
    end else begin
      if (wr_cfg) cfg_q <= wdata & CFG_MASK;
      if (any_wr)   cnt_q <= wide[CW-1:0];
      else if (inc) cnt_q <= cnt_inc;
      if (wr_tlo) thr_q[31:0]  <= wdata;
      if (wr_thi) thr_q[63:32] <= wdata;
    end
  end

  assign cfg_o = cfg_q;
  assign cnt_o = 64'(cnt_q);
  assign thr_o = thr_q;
  assign hit_o = inc && !any_wr && (64'(cnt_inc) == thr_q);

  AST_NEVER_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (code == '0 && !any_wr) |=> cnt_q == $past(cnt_q)); // R2
  AST_RUN_GATE: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !any_wr) |=> cnt_q == $past(cnt_q)); // R3
  AST_KERN_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_q[KERN_BIT] && !priv_kernel && !any_wr) |=> cnt_q == $past(cnt_q)); // R4
  AST_WRITE_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    wr_clo |=> cnt_q[31:0] == $past(wdata)); // R5
endmodule

// File: rtl/pcu_irq.sv
module pcu_irq #(
  parameter int N = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] hit,
  input  logic         wr_ien,
  input  logic         wr_iact,
  input  logic [N-1:0] wdata,
  output logic [N-1:0] ien_o,
  output logic [N-1:0] act_o,
  output logic         irq
);
  logic [N-1:0] ien_q, act_q, set, clr;

  assign set = hit & ien_q;
  assign clr = wr_iact ? wdata : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ien_q <= '0;
      act_q <= '0;
    end else begin
      if (wr_ien) ien_q <= wdata;
      else        ien_q <= ien_q & ~clr;
      act_q <= (act_q & ~clr) | set;
    end
  end

  assign ien_o = ien_q;
  assign act_o = act_q;
  assign irq   = |(act_q & ien_q);

  AST_CLEAR_DISARMS: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_iact && !wr_ien) |=> (ien_q & $past(wdata)) == '0); // R9
  AST_NO_SET_DISABLED: assert property (@(posedge clk) disable iff (!rst_n)
    (ien_q == '0) |=> (act_q & ~$past(act_q)) == '0); // R10
endmodule

// File: rtl/perf_counter_unit.sv
module perf_counter_unit #(
  parameter int NUM_CTR  = 4,
  parameter int NUM_EVT  = 8,
  parameter int SIZE_SEL = 1,
  parameter int ADDR_W   = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               bus_wr,
  input  logic [ADDR_W-1:0]  bus_addr,
  input  logic [31:0]        bus_wdata,
  output logic [31:0]        bus_rdata,
  input  logic [NUM_EVT-1:0] evt_in,
  input  logic               priv_kernel,
  output logic               irq
);
  import pcu_pkg::*;

  localparam int CW    = 32 + 16 * SIZE_SEL;
  localparam int IDX_W = (NUM_CTR > 1) ? $clog2(NUM_CTR) : 1;

  logic             run_q;
  logic [IDX_W-1:0] sel_q;
  logic [63:0]      snap_q;
  logic             sel_ok;
  logic [31:0]      cfg_all [NUM_CTR];
  logic [63:0]      cnt_all [NUM_CTR];
  logic [63:0]      thr_all [NUM_CTR];
  logic [NUM_CTR-1:0] hit, ien, act;
  logic [31:0]      cfg_sel;
  logic [63:0]      cnt_sel, thr_sel;
  logic             wr_ctrl;

  function automatic logic wr_at(input int a);
    return bus_wr && (bus_addr == ADDR_W'(a));
  endfunction

  assign sel_ok  = (32'(sel_q) < NUM_CTR);
  assign wr_ctrl = wr_at(A_CTRL);

  for (genvar i = 0; i < NUM_CTR; i++) begin : g_ctr
    logic me;
    assign me = sel_ok && (sel_q == IDX_W'(i));
    pcu_slice #(.NUM_EVT(NUM_EVT), .CW(CW)) u_slice (
      .clk(clk), .rst_n(rst_n), .run(run_q), .priv_kernel(priv_kernel),
      .evt_in(evt_in),
      .wr_cfg(me && wr_at(A_CFG)), .wr_clo(me && wr_at(A_CLO)),
      .wr_chi(me && wr_at(A_CHI)), .wr_tlo(me && wr_at(A_TLO)),
      .wr_thi(me && wr_at(A_THI)), .wdata(bus_wdata),
      .cfg_o(cfg_all[i]), .cnt_o(cnt_all[i]), .thr_o(thr_all[i]), .hit_o(hit[i])
    );
  end

  pcu_irq #(.N(NUM_CTR)) u_irq (
    .clk(clk), .rst_n(rst_n), .hit(hit),
    .wr_ien(wr_at(A_IEN)), .wr_iact(wr_at(A_IACT)),
    .wdata(bus_wdata[NUM_CTR-1:0]),
    .ien_o(ien), .act_o(act), .irq(irq)
  );

  assign cfg_sel = sel_ok ? cfg_all[sel_q] : '0;
  assign cnt_sel = sel_ok ? cnt_all[sel_q] : '0;
  assign thr_sel = sel_ok ? thr_all[sel_q] : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q  <= 1'b0;
      sel_q  <= '0;
      snap_q <= '0;
    end else begin
      if (wr_ctrl) begin
        run_q <= bus_wdata[0];
        if (bus_wdata[1]) snap_q <= cnt_sel;
      end
      if (wr_at(A_SEL)) sel_q <= bus_wdata[IDX_W-1:0];
    end
  end

  always_comb begin
    bus_rdata = '0;
    case (32'(bus_addr))
      A_CTRL: bus_rdata = {31'b0, run_q};
      A_SEL:  bus_rdata = 32'(sel_q);
      A_CFG:  bus_rdata = cfg_sel;
      A_CLO:  bus_rdata = cnt_sel[31:0];
      A_CHI:  bus_rdata = cnt_sel[63:32];
      A_SLO:  bus_rdata = snap_q[31:0];
      A_SHI:  bus_rdata = snap_q[63:32];
      A_TLO:  bus_rdata = thr_sel[31:0];
      A_THI:  bus_rdata = thr_sel[63:32];
      A_IEN:  bus_rdata = 32'(ien);
      A_IACT: bus_rdata = 32'(act);
      default: bus_rdata = '0;
    endcase
  end

  AST_SNAP_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ctrl && bus_wdata[1]) |=> snap_q == $past(cnt_sel)); // R7
  AST_IRQ_NEEDS_ACT: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (act != '0)); // R8
endmodule

// File: tb/perf_counter_unit_test.sv
`timescale 1ns/1ps
module perf_counter_unit_test;
  localparam int NE = 8;
  logic clk = 1'b0, rst_n = 1'b0, bus_wr = 1'b0, priv_kernel = 1'b0;
  logic [3:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0, bus_rdata;
  logic [NE-1:0] evt_in = '0;
  logic irq;
  int checks = 0, errors = 0;
  logic [31:0] rv, live;

  perf_counter_unit uut (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .evt_in(evt_in),
    .priv_kernel(priv_kernel), .irq(irq)
  );

  always #2.5 clk = ~clk;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input int a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = 4'(a); bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input int a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = 4'(a);
    #0.5 d = bus_rdata;
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic fresh(input int c, input logic [31:0] cfg);
    wr(1, c); wr(2, cfg); wr(3, 0); wr(4, 0);
  endtask

  initial begin
    #1000000;
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    cyc(3); rst_n = 1'b1;
    // R11 reset state
    rd(0, rv); chk("R11 ctrl", rv, 0);
    rd(3, rv); chk("R11 count", rv, 0);
    rd(9, rv); chk("R11 ien", rv, 0);
    chk("R11 irq", 32'(irq), 0);

    wr(0, 1);
    // R2 sweep: every counter, every event code
    for (int c = 0; c < 4; c++)
      for (int k = 1; k <= NE; k++) begin
        fresh(c, k);
        evt_in = ~(NE'(1) << (k - 1)); cyc(3);
        evt_in = NE'(1) << (k - 1); cyc(k + c);
        evt_in = '0;
        rd(3, rv); chk($sformatf("R2 ctr%0d code%0d", c, k), rv, 32'(k + c));
      end

    // R2 code 0 and out-of-range code never count
    fresh(0, 0); wr(3, 7);
    evt_in = '1; cyc(6); evt_in = '0;
    rd(3, rv); chk("R2 code0 never", rv, 7);
    fresh(0, NE + 1);
    evt_in = '1; cyc(6); evt_in = '0;
    rd(3, rv); chk("R2 code beyond range", rv, 0);

    // R3 run bit
    wr(0, 0); fresh(0, 1);
    evt_in = 1; cyc(6); evt_in = '0;
    rd(3, rv); chk("R3 stopped", rv, 0);
    wr(0, 1);

    // R4 mode qualifiers
    fresh(0, 32'h1_0001);
    evt_in = 1; priv_kernel = 0; cyc(5); priv_kernel = 1; cyc(4); evt_in = '0;
    rd(3, rv); chk("R4 kernel only", rv, 4);
    fresh(0, 32'h2_0001);
    evt_in = 1; priv_kernel = 0; cyc(3); priv_kernel = 1; cyc(6); evt_in = '0;
    priv_kernel = 0;
    rd(3, rv); chk("R4 user only", rv, 3);

    // R5 write against increment on the same edge
    fresh(0, 1);
    evt_in = 1;
    wr(3, 100);
    bus_addr = 4'd3; #0.5 chk("R5 low write wins", bus_rdata, 100);
    wr(4, 32'h1234);
    evt_in = '0;
    rd(3, rv); chk("R5 low kept on high write", rv, 101);
    rd(4, rv); chk("R5 high write", rv, 32'h1234);

    // R6 width and wrap
    wr(4, 32'hFFFF_FFFF);
    rd(4, rv); chk("R6 high width", rv, 32'h0000_FFFF);
    wr(3, 32'hFFFF_FFFF);
    evt_in = 1; cyc(1); evt_in = '0;
    rd(3, rv); chk("R6 wrap low", rv, 0);
    rd(4, rv); chk("R6 wrap high", rv, 0);

    // R7 snapshot while counting
    fresh(0, 1); wr(3, 50);
    evt_in = 1; cyc(3);
    wr(0, 3);
    evt_in = '0;
    rd(3, live); chk("R7 live count", live, 55);
    rd(5, rv); chk("R7 snapshot low", rv, 54);
    rd(6, rv); chk("R7 snapshot high", rv, 0);
    rd(0, rv); chk("R7 ctrl readback", rv, 1);

    // R1 isolation between counters
    wr(1, 0); wr(3, 32'hAAAA);
    wr(1, 1); wr(3, 32'h5555);
    wr(1, 0); rd(3, rv); chk("R1 other counter kept", rv, 32'hAAAA);
    wr(1, 1); rd(3, rv); chk("R1 selected counter", rv, 32'h5555);

    // R8 threshold interrupt, R9 clear
    for (int c = 1; c < 4; c++) fresh(c, 0);
    fresh(2, 1); wr(7, 5); wr(8, 0); wr(9, 4);
    evt_in = 1; cyc(4); evt_in = '0;
    cyc(1); chk("R8 below threshold", 32'(irq), 0);
    evt_in = 1; cyc(1); evt_in = '0;
    cyc(1); chk("R8 irq at threshold", 32'(irq), 1);
    rd(10, rv); chk("R8 active bit", rv, 4);
    wr(10, 4);
    chk("R9 irq cleared", 32'(irq), 0);
    rd(9, rv); chk("R9 enable disarmed", rv, 0);
    rd(10, rv); chk("R9 active cleared", rv, 0);

    // R10 disabled counter
    wr(3, 0);
    evt_in = 1; cyc(6); evt_in = '0;
    rd(10, rv); chk("R10 no active when disabled", rv, 0);
    chk("R10 irq low", 32'(irq), 0);

    // R9 all-ones clear
    wr(3, 0);
    fresh(0, 1); wr(7, 3); wr(8, 0);
    wr(9, 5);
    evt_in = 1; cyc(6); evt_in = '0;
    rd(10, rv); chk("R8 two active", rv, 5);
    chk("R8 irq two", 32'(irq), 1);
    wr(10, 32'hFFFF_FFFF);
    rd(10, rv); chk("R9 all cleared", rv, 0);
    rd(9, rv); chk("R9 all disarmed", rv, 0);
    chk("R9 irq low", 32'(irq), 0);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule